// File: doc/BRIEF.md
# Prime step counter

A three-bit synchronous state machine that walks the prime values below eight on every rising clock edge, in the closed order 2, 3, 5, 7 and back to 2. The three state bits sit in D-type storage. The next state is a pure combinational function of the current three bits, so the block has no count enable, no direction control and no load path.

Four of the eight codes are legal: 010, 011, 101 and 111. The other four (000, 001, 100 and 110) are unused. They can only appear at power-up, and each one leads to 111 on the following edge. The counter therefore joins its loop after at most one clock, with or without reset. An optional active-high synchronous reset also loads 111. A combinational flag reports whether the present code lies on the loop.

States: ST_P2 (010), ST_P3 (011), ST_P5 (101) and ST_P7 (111) are legal. ST_X0 (000), ST_X1 (001), ST_X4 (100) and ST_X6 (110) are unused. Transitions: P2→P3, P3→P5, P5→P7 and P7→P2 (the wrap). Each of X0, X1, X4 and X6 goes to P7 (recovery). Reset takes any state to P7.

The parameter `NEXT_STYLE` selects how the next-state logic is built: 0 gives sum-of-products equations, 1 gives a per-state case table. `POWERUP_CODE` sets the register's initial content, which models a start-up in any code.

Top module: `prime_step_counter`

## Requirements
- R1: With `srst` low, each rising edge moves the legal codes in the order 010 → 011 → 101 → 111 → 010 on `count`.
- R2: With `srst` low, each unused code 000, 001, 100 or 110 becomes 111 at the next rising edge.
- R3: When `srst` is high at a rising edge, `count` becomes 111 at that edge, whatever the current code.
- R4: There is no enable. With `srst` low, `count` takes a different value after every rising edge.
- R5: `in_seq` is 1 exactly when `count` is 010, 011, 101 or 111, and 0 for the other four codes. It follows `count` with no added register.
- R6: A counter that starts in any unused code, with `srst` held low, shows 111 after its first rising edge and then continues the R1 order.
- R7: Both `NEXT_STYLE` settings (0 = equations, 1 = case table) give the same `count` sequence for the same reset pattern.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the state updates on the rising edge |
| srst | input | 1 | Synchronous reset, active high; loads 111 |
| count | output | 3 | Current state code |
| in_seq | output | 1 | High while `count` is one of the four legal codes |

## Verification
The hardest cases are the four unused codes. The bench reaches them through separate instances whose power-up content is each of those codes, with reset never asserted. A design that left one of them unmapped would sit in a dead pair or a lock-up loop, and would never show 111 after one edge. The wrap from 111 to 010 is checked over two full loops; a design that got it wrong would stall at 7 or drop into binary counting. Random reset pulses in the middle of the loop show whether reset wins over the next-state logic from every state. Running both implementation styles side by side exposes any equation that differs from the table in a single minterm.

// File: rtl/prime_step_pkg.sv
package prime_step_pkg;

    localparam int STATE_W = 3;

    localparam int NS_SOP   = 0;
    localparam int NS_TABLE = 1;

    typedef enum logic [STATE_W-1:0] {
        ST_X0 = 3'b000,
        ST_X1 = 3'b001,
        ST_P2 = 3'b010,
        ST_P3 = 3'b011,
        ST_X4 = 3'b100,
        ST_P5 = 3'b101,
        ST_X6 = 3'b110,
        ST_P7 = 3'b111
    } state_t;

    localparam state_t RECOVER_ST = ST_P7;

endpackage

// File: rtl/prime_step_next.sv
module prime_step_next
    import prime_step_pkg::*;
#(
    parameter int NEXT_STYLE = NS_SOP
) (
    input  state_t cur_st,
    output state_t nxt_st
);

    generate
        if (NEXT_STYLE == NS_SOP) begin : g_sop
            logic q3, q2, q1;
            logic d3, d2, d1;
            always_comb begin
                q3 = cur_st[2];
                q2 = cur_st[1];
                q1 = cur_st[0];
                d3 = (~q2) | (q3 & ~q1) | (~q3 & q1);
                d2 = q3 | ~q2 | ~q1;
                d1 = ~q3 | ~q2 | ~q1;
                nxt_st = state_t'({d3, d2, d1});
            end
        end else begin : g_table
            always_comb begin
                unique case (cur_st)
                    ST_P2:   nxt_st = ST_P3;
                    ST_P3:   nxt_st = ST_P5;
                    ST_P5:   nxt_st = ST_P7;
                    ST_P7:   nxt_st = ST_P2;
                    ST_X0:   nxt_st = RECOVER_ST;
                    ST_X1:   nxt_st = RECOVER_ST;
                    ST_X4:   nxt_st = RECOVER_ST;
                    ST_X6:   nxt_st = RECOVER_ST;
                    default: nxt_st = RECOVER_ST;
                endcase
            end
        end
    endgenerate

endmodule

// File: rtl/prime_step_state.sv
module prime_step_state
    import prime_step_pkg::*;
#(
    parameter logic [STATE_W-1:0] POWERUP_CODE = 3'b000
) (
    input  logic   clk,
    input  logic   srst,
    input  state_t nxt_st,
    output state_t cur_st
);

    state_t state_q = state_t'(POWERUP_CODE);

    always_ff @(posedge clk) begin
        if (srst) begin
            state_q <= RECOVER_ST;
        end else begin
            state_q <= nxt_st;
        end
    end

    assign cur_st = state_q;

endmodule

// File: rtl/prime_step_legal.sv
module prime_step_legal
    import prime_step_pkg::*;
(
    input  state_t cur_st,
    output logic   legal
);

    always_comb begin
        unique case (cur_st)
            ST_P2, ST_P3, ST_P5, ST_P7: legal = 1'b1;
            ST_X0, ST_X1, ST_X4, ST_X6: legal = 1'b0;
            default:                    legal = 1'b0;
        endcase
    end

endmodule

// File: rtl/prime_step_counter.sv
module prime_step_counter
    import prime_step_pkg::*;
#(
    parameter int                 NEXT_STYLE   = NS_SOP,
    parameter logic [STATE_W-1:0] POWERUP_CODE = 3'b000
) (
    input  logic               clk,
    input  logic               srst,
    output logic [STATE_W-1:0] count,
    output logic               in_seq
);

    state_t cur_st;
    state_t nxt_st;

    prime_step_next #(
        .NEXT_STYLE(NEXT_STYLE)
    ) u_next (
        .cur_st(cur_st),
        .nxt_st(nxt_st)
    );

    prime_step_state #(
        .POWERUP_CODE(POWERUP_CODE)
    ) u_state (
        .clk   (clk),
        .srst  (srst),
        .nxt_st(nxt_st),
        .cur_st(cur_st)
    );

    prime_step_legal u_legal (
        .cur_st(cur_st),
        .legal (in_seq)
    );

    assign count = cur_st;

endmodule

// File: rtl/prime_step_counter_chk.sv
module prime_step_counter_chk (
    input logic       clk,
    input logic       srst,
    input logic [2:0] count,
    input logic       in_seq
);

    logic armed = 1'b0;
    always_ff @(posedge clk) armed <= 1'b1;

    // R1
    p2_to_p3_chk: assert property (@(posedge clk) disable iff (srst)
        (count == 3'b010) |=> (count == 3'b011));

    // R1
    p3_to_p5_chk: assert property (@(posedge clk) disable iff (srst)
        (count == 3'b011) |=> (count == 3'b101));

    // R1
    p5_to_p7_chk: assert property (@(posedge clk) disable iff (srst)
        (count == 3'b101) |=> (count == 3'b111));

    // R1
    p7_wrap_chk: assert property (@(posedge clk) disable iff (srst)
        (count == 3'b111) |=> (count == 3'b010));

    // R2
    unused_recover_chk: assert property (@(posedge clk) disable iff (srst)
        (!in_seq) |=> (count == 3'b111));

    // R3
    reset_load_chk: assert property (@(posedge clk) disable iff (!armed)
        srst |=> (count == 3'b111));

    // R4
    always_moves_chk: assert property (@(posedge clk) disable iff (srst)
        1'b1 |=> (count != $past(count)));

    // R5
    loop_closed_chk: assert property (@(posedge clk) disable iff (srst)
        in_seq |=> in_seq);

endmodule

bind prime_step_counter prime_step_counter_chk u_chk (
    .clk   (clk),
    .srst  (srst),
    .count (count),
    .in_seq(in_seq)
);

// File: tb/prime_step_counter_test.sv
module prime_step_counter_test;

    localparam int CLK_PERIOD = 10;
    localparam int RAND_STEPS = 300;

    logic       clk = 1'b0;
    logic       srst = 1'b1;
    logic [2:0] count, alt_count;
    logic       in_seq, alt_in_seq;
    logic [2:0] pu_count [4];
    logic       pu_in    [4];

    int n_chk = 0;
    int n_bad = 0;
    logic [2:0] exp_st;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    prime_step_counter #(.NEXT_STYLE(0)) uut (
        .clk(clk), .srst(srst), .count(count), .in_seq(in_seq));

    prime_step_counter #(.NEXT_STYLE(1)) alt (
        .clk(clk), .srst(srst), .count(alt_count), .in_seq(alt_in_seq));

    function automatic logic [2:0] unused_code(int idx);
        case (idx)
            0: return 3'b000;
            1: return 3'b001;
            2: return 3'b100;
            default: return 3'b110;
        endcase
    endfunction

    for (genvar g = 0; g < 4; g++) begin : g_pu
        prime_step_counter #(.NEXT_STYLE(g % 2), .POWERUP_CODE(unused_code(g))) pu (
            .clk(clk), .srst(1'b0), .count(pu_count[g]), .in_seq(pu_in[g]));
    end

    function automatic logic [2:0] next_of(logic [2:0] s);
        case (s)
            3'b010: return 3'b011;
            3'b011: return 3'b101;
            3'b101: return 3'b111;
            3'b111: return 3'b010;
            default: return 3'b111;
        endcase
    endfunction

    function automatic logic is_legal(logic [2:0] s);
        return (s == 3'b010) || (s == 3'b011) || (s == 3'b101) || (s == 3'b111);
    endfunction

    task automatic check3(string req, logic [2:0] act, logic [2:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic check1(string req, logic act, logic exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic step(logic rst);
        srst = rst;
        @(posedge clk);
        exp_st = rst ? 3'b111 : next_of(exp_st);
        @(negedge clk);
        check3("R1/R3 count", count, exp_st);
        check1("R5 in_seq", in_seq, is_legal(exp_st));
        check3("R7 style match", alt_count, count);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual running expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2357));
        // R6/R5: power-up contents before the first edge
        #2;
        for (int i = 0; i < 4; i++) begin
            check3("R6 power-up code", pu_count[i], unused_code(i));
            check1("R5 flag low on unused", pu_in[i], 1'b0);
        end
        // R2/R6: one edge later every unused code sits at 111
        @(negedge clk);
        for (int i = 0; i < 4; i++) begin
            check3("R2 recovery to 111", pu_count[i], 3'b111);
            check1("R5 flag high after recovery", pu_in[i], 1'b1);
        end
        @(negedge clk);
        for (int i = 0; i < 4; i++)
            check3("R6 joins loop at 010", pu_count[i], 3'b010);

        // R3: reset state
        check3("R3 reset state", count, 3'b111);
        check1("R5 flag after reset", in_seq, 1'b1);
        exp_st = 3'b111;

        // R1/R4: two full loops from 111
        begin
            logic [2:0] loop_seq [8];
            logic [2:0] prev;
            loop_seq = '{3'b111, 3'b010, 3'b011, 3'b101, 3'b111, 3'b010, 3'b011, 3'b101};
            srst = 1'b0;
            check3("R1 loop start", count, loop_seq[0]);
            for (int k = 1; k < 8; k++) begin
                prev = count;
                @(negedge clk);
                check3("R1 two-loop order", count, loop_seq[k]);
                n_chk++;
                if (count === prev) begin
                    n_bad++;
                    $display("FAIL R4 no advance: actual %b expected not %b", count, prev);
                end
            end
            exp_st = count;
        end

        // R3: reset from each legal state
        for (int k = 0; k < 4; k++) begin
            for (int j = 0; j < k; j++) step(1'b0);
            step(1'b1);
        end

        // R1/R3/R5/R7: random reset pulses
        for (int k = 0; k < RAND_STEPS; k++)
            step(($urandom % 5) == 0);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule